// File: doc/BRIEF.md
# SPI Status-Register Front-End for a Serial Memory Model

This block is the command front-end of a serial memory model. It acts as an SPI slave in mode 0 and handles only the commands that touch the status register: read status, write status, set write-enable and clear write-enable. The serial pins are sampled by a fast system clock. SCK edges are found by comparing each SCK sample with the one before it. An instruction is accepted when chip select rises, and only if the number of SCK clocks in the frame was exactly right.

The status byte holds a write-protect-enable bit, two block-protect bits, the write-enable latch and a write-in-progress flag. The protect bits model nonvolatile cells, so the ordinary reset does not clear them; only a separate initialisation reset does. A status write that is accepted starts a busy period of a set number of system clocks, which stands in for the real programming time. The block also gives the array-write path the protected region as an enable and a base address, plus a go/no-go answer for an address that the path presents.

Top module: `spi_status_frontend`

## Requirements
- R1: After `rst_n` and `nv_rst_n` have both been asserted, a status read returns 0x00, `so_en` is 0, `prot_en` is 0 and `chk_ok` is 0.
- R2: Opcode 0x05 (read status), sent MSB first on SI with bits sampled on SCK rising edges, makes the block drive the status byte MSB first on SO during clocks 8 to 15. A new bit appears after each SCK falling edge. `so_en` is 0 during clocks 0 to 7 and whenever chip select is high.
- R3: The status byte is bit 7 write-protect-enable, bits 6 to 4 always 0, bit 3 block-protect 1, bit 2 block-protect 0, bit 1 write-enable latch, bit 0 write-in-progress.
- R4: If chip select stays low after a read-status byte, each further group of 8 clocks sends the status byte again, sampled fresh at the start of that group.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either one acts only when chip select rises after exactly 8 clocks. With any other clock count, nothing changes.
- R6: Opcode 0x01 followed by a data byte, ended after exactly 16 clocks while the latch is 1, loads data bits 7, 3 and 2 into write-protect-enable and the block-protect bits. All other data bits are ignored. In every other case the status is left unchanged.
- R7: While write-protect-enable is 1 and `wp_n` is 0, status writes are rejected, but opcodes 0x06 and 0x04 still change the latch.
- R8: An accepted status write holds write-in-progress at 1 for BUSY_CYCLES system clocks, then clears both write-in-progress and the latch. While busy, only read status has any effect.
- R9: Read status works during the busy period and shows write-in-progress as 1 there.
- R10: Any opcode other than the four listed is ignored until chip select goes high.
- R11: Asserting only `rst_n` clears the latch and write-in-progress but keeps write-protect-enable and the block-protect bits.
- R12: Block-protect code 00 protects nothing, 01 protects from 3/4 of the array upward, 10 from 1/2 upward, and 11 protects the whole array. `prot_en` and `prot_base` report this region. `chk_ok` is 1 only when the latch is 1, no write is in progress and `chk_addr` is outside the protected region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset of volatile state (models a power cycle) |
| nv_rst_n | input | 1 | Active-low initialisation of the nonvolatile status bits |
| sck | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low hardware write-protect |
| chk_addr | input | ADDR_W | Address queried by the array-write path |
| so | output | 1 | Serial data out, valid when so_en is 1 |
| so_en | output | 1 | Output enable for SO (0 means high-impedance) |
| prot_en | output | 1 | Some part of the array is protected |
| prot_base | output | ADDR_W | Lowest protected address |
| chk_ok | output | 1 | Array write to chk_addr is allowed now |

## Verification
The case where two functions meet in the same period is a status read issued while a write cycle is still running. The write-in-progress flag and the just-written protect bits must come out correctly while the busy counter keeps running. A second such case is a set or clear write-enable command arriving during the busy period. That command must be ignored, and the latch must still be cleared when the busy period ends. The bench sets both cases up directly after accepted status writes, and also reaches them again through random command streams. Every read byte is compared against a bench model of the status register.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;

    // Bits of the status byte that a status write may change
    localparam logic [7:0] NV_MASK = 8'h8C;

    localparam int CNT_W = 5;

    typedef struct packed {
        logic             sck;
        logic             cs_n;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       bitpos;
        logic [7:0]       op;
        logic [7:0]       dat;
        logic [7:0]       sr;
        logic             oe;
    } link_st_t;

endpackage

// File: rtl/spi_sr_link.sv
module spi_sr_link
    import spi_sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             si,
    input  logic [7:0]       status,
    output logic             cs_end,
    output logic [CNT_W-1:0] cnt,
    output logic [7:0]       op,
    output logic [7:0]       dat,
    output logic             so,
    output logic             so_en
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] OP_BITS = CNT_W'(8);

    link_st_t q, d;
    logic rise, fall, rd_mode;

    always_comb begin
        d       = q;
        d.sck   = sck;
        d.cs_n  = cs_n;
        rise    = sck & ~q.sck & ~cs_n;
        fall    = ~sck & q.sck & ~cs_n;
        rd_mode = (q.op == OP_RDSR) && (q.cnt >= OP_BITS);
        if (cs_n) begin
            d.cnt    = '0;
            d.bitpos = '0;
            d.op     = '0;
            d.oe     = 1'b0;
        end else begin
            if (rise) begin
                if (q.cnt < OP_BITS) d.op  = {q.op[6:0], si};
                else                 d.dat = {q.dat[6:0], si};
                if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
                d.bitpos = q.bitpos + 1'b1;
            end
            if (fall && rd_mode) begin
                d.oe = 1'b1;
                if (q.bitpos == 3'd0) d.sr = status;
                else                  d.sr = {q.sr[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_end = cs_n & ~q.cs_n;
    assign cnt    = q.cnt;
    assign op     = q.op;
    assign dat    = q.dat;
    assign so     = q.sr[7];
    assign so_en  = q.oe;

    // R2: SO stays released while chip select is held high
    a_r2_hiz_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !so_en);

    // R2: no output drive during the opcode phase
    a_r2_quiet_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt < OP_BITS) |-> !q.oe);

endmodule

// File: rtl/spi_sr_busy.sv
module spi_sr_busy #(
    parameter int BUSY_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(BUSY_CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    // R8: a write cycle is never restarted while one is running
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R8: an accepted write shows as busy on the next cycle
    a_r8_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

endmodule

// File: rtl/spi_sr_protect.sv
module spi_sr_protect #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        bp,
    input  logic              wel,
    input  logic              wip,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              prot_en,
    output logic [ADDR_W-1:0] prot_base,
    output logic              chk_ok
);

    localparam int LOW_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] BASE_QTR  = {2'b11, {LOW_W{1'b0}}};
    localparam logic [ADDR_W-1:0] BASE_HALF = {2'b10, {LOW_W{1'b0}}};

    always_comb begin
        prot_en = (bp != 2'b00);
        unique case (bp)
            2'b01:   prot_base = BASE_QTR;
            2'b10:   prot_base = BASE_HALF;
            default: prot_base = '0;
        endcase
        chk_ok = wel && !wip && !(prot_en && (chk_addr >= prot_base));
    end

endmodule

// File: rtl/spi_status_frontend.sv
module spi_status_frontend
    import spi_sr_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int BUSY_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              so,
    output logic              so_en,
    output logic              prot_en,
    output logic [ADDR_W-1:0] prot_base,
    output logic              chk_ok
);

    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(8);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(16);

    logic [7:0]       nv_d, nv_q;
    logic             wel_d, wel_q;
    logic             cs_end, busy, done, locked, start;
    logic             hit_set, hit_clr;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       op, dat, status;

    assign status = nv_q | {6'b0, wel_q, busy};

    spi_sr_link u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck    (sck),
        .cs_n   (cs_n),
        .si     (si),
        .status (status),
        .cs_end (cs_end),
        .cnt    (cnt),
        .op     (op),
        .dat    (dat),
        .so     (so),
        .so_en  (so_en)
    );

    spi_sr_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    spi_sr_protect #(.ADDR_W(ADDR_W)) u_prot (
        .bp        (nv_q[3:2]),
        .wel       (wel_q),
        .wip       (busy),
        .chk_addr  (chk_addr),
        .prot_en   (prot_en),
        .prot_base (prot_base),
        .chk_ok    (chk_ok)
    );

    always_comb begin
        nv_d    = nv_q;
        wel_d   = wel_q;
        locked  = nv_q[7] & ~wp_n;
        hit_set = cs_end && !busy && (cnt == LEN_SHORT) && (op == OP_WREN);
        hit_clr = cs_end && !busy && (cnt == LEN_SHORT) && (op == OP_WRDI);
        start   = cs_end && !busy && (cnt == LEN_LONG) && (op == OP_WRSR)
                  && wel_q && !locked;
        if (done)    wel_d = 1'b0;
        if (hit_set) wel_d = 1'b1;
        if (hit_clr) wel_d = 1'b0;
        if (start)   nv_d  = dat & NV_MASK;
    end

    always_ff @(posedge clk or negedge nv_rst_n) begin
        if (!nv_rst_n) nv_q <= '0;
        else           nv_q <= nv_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wel_q <= 1'b0;
        else        wel_q <= wel_d;
    end

    // R8: the latch is clear once a write cycle ends
    a_r8_wel_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel_q);

    // R8: the latch cannot be set during a write cycle
    a_r8_no_set_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(!busy));

    // R8: protect bits are frozen during the busy period
    a_r8_nv_frozen: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        (busy && $past(busy)) |-> $stable(nv_q));

    // R6: a status write is only launched with the latch set
    a_r6_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> wel_q);

    // R7: a hardware lock keeps the protect bits unchanged
    a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        (nv_q[7] && !wp_n) |=> $stable(nv_q));

    // R12: full protection forbids every array write
    a_r12_full_block: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_q[3:2] == 2'b11) |-> !chk_ok);

endmodule

// File: tb/sim_spi_status_frontend.sv
module sim_spi_status_frontend;

    localparam int AW    = 11;
    localparam int BUSY  = 400;
    localparam int HALF  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0, nv_rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
    logic [AW-1:0] chk_addr = '0;
    logic so, so_en, prot_en, chk_ok;
    logic [AW-1:0] prot_base;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    logic       m_wpen = 0, m_wel = 0, m_wip = 0;
    logic [1:0] m_bp = 0;

    always #5 clk = ~clk;

    spi_status_frontend #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .sck(sck), .cs_n(cs_n),
        .si(si), .wp_n(wp_n), .chk_addr(chk_addr), .so(so), .so_en(so_en),
        .prot_en(prot_en), .prot_base(prot_base), .chk_ok(chk_ok)
    );

    function automatic logic [7:0] exp_status();
        return {m_wpen, 3'b000, m_bp, m_wel, m_wip};
    endfunction

    function automatic logic [AW-1:0] exp_base(input logic [1:0] bp);
        case (bp)
            2'b01:   return AW'(3) << (AW - 2);
            2'b10:   return AW'(2) << (AW - 2);
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic spi(input logic [31:0] tx, input int n, output logic [31:0] rx,
                       output logic en_early, output logic en_late);
        rx = '0; en_early = 1'b0; en_late = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            si = tx[31-i];
            repeat (HALF) @(negedge clk);
            rx = {rx[30:0], so};
            if (i < 8) en_early |= so_en;
            else       en_late  &= so_en;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1; si = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic model_apply(input logic [7:0] op, input logic [7:0] data, input int n);
        if (m_wip) return;
        if (n == 8 && op == 8'h06)      m_wel = 1'b1;
        else if (n == 8 && op == 8'h04) m_wel = 1'b0;
        else if (n == 16 && op == 8'h01 && m_wel && !(m_wpen && !wp_n)) begin
            m_wpen = data[7];
            m_bp   = data[3:2];
            m_wip  = 1'b1;
        end
    endtask

    task automatic cmd(input logic [7:0] op, input logic [7:0] data, input int n);
        logic [31:0] rx;
        logic e0, e1;
        spi({op, data, 16'h0}, n, rx, e0, e1);
        model_apply(op, data, n);
    endtask

    task automatic read_check(input string tag, input int nbytes);
        logic [31:0] rx;
        logic e0, e1;
        spi({8'h05, 24'h0}, 8 + 8 * nbytes, rx, e0, e1);
        for (int b = 0; b < nbytes; b++)
            chk(tag, 32'(rx[8*(nbytes-1-b) +: 8]), 32'(exp_status()));
        chk("R2 so_en in opcode phase", 32'(e0), 32'd0);
        chk("R2 so_en in data phase", 32'(e1), 32'd1);
        chk("R2 so_en after deselect", 32'(so_en), 32'd0);
    endtask

    task automatic wait_busy();
        if (m_wip) begin
            repeat (BUSY + 20) @(negedge clk);
            m_wip = 1'b0;
            m_wel = 1'b0;
        end
    endtask

    task automatic prot_check(input string tag);
        logic exp_ok;
        chk_addr = AW'($urandom);
        @(negedge clk);
        exp_ok = m_wel && !m_wip && !((m_bp != 0) && (chk_addr >= exp_base(m_bp)));
        chk({tag, " prot_en"}, 32'(prot_en), 32'(m_bp != 0));
        chk({tag, " prot_base"}, 32'(prot_base), 32'(exp_base(m_bp)));
        chk({tag, " chk_ok"}, 32'(chk_ok), 32'(exp_ok));
    endtask

    task automatic power_cycle();
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        m_wel = 1'b0; m_wip = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst_n = 1'b1; nv_rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 so_en", 32'(so_en), 32'd0);
        chk("R1 prot_en", 32'(prot_en), 32'd0);
        chk("R1 chk_ok", 32'(chk_ok), 32'd0);
        read_check("R1 status after reset", 1);

        // R5 set latch
        cmd(8'h06, 8'h00, 8);
        read_check("R5 latch set", 1);
        prot_check("R12 open");

        // R6 R9 write protect bits, read during busy
        cmd(8'h01, 8'h8C, 16);
        read_check("R9 status while busy", 1);
        // R8 set/clear ignored while busy
        cmd(8'h04, 8'h00, 8);
        read_check("R8 clear ignored while busy", 1);
        prot_check("R12 busy");
        wait_busy();
        read_check("R8 after write cycle", 1);
        prot_check("R12 full");

        // R11 power cycle keeps nonvolatile bits
        power_cycle();
        read_check("R11 after power cycle", 1);

        // R7 hardware lock
        wp_n = 1'b0;
        cmd(8'h06, 8'h00, 8);
        read_check("R7 latch set under lock", 1);
        cmd(8'h01, 8'h00, 16);
        read_check("R7 write rejected", 1);
        cmd(8'h04, 8'h00, 8);
        read_check("R7 latch cleared under lock", 1);
        wp_n = 1'b1;

        // R6 write rejected without latch
        cmd(8'h01, 8'h00, 16);
        read_check("R6 no latch", 1);

        // R10 unknown opcode, R5 wrong clock counts
        cmd(8'h03, 8'h00, 8);
        read_check("R10 unknown opcode", 1);
        cmd(8'h06, 8'h00, 7);
        read_check("R5 short frame", 1);
        cmd(8'h06, 8'h00, 9);
        read_check("R5 long frame", 1);
        cmd(8'h06, 8'h00, 8);
        cmd(8'h01, 8'h00, 15);
        read_check("R6 15 clocks", 1);

        // R3 R6 unused and read-only data bits ignored
        cmd(8'h01, 8'h73, 16);
        read_check("R3 data bits 6:4,1:0 ignored", 1);
        wait_busy();
        read_check("R3 after write", 1);

        // R4 continuous read
        read_check("R4 repeated status", 3);

        // R12 each protect code
        for (int c = 1; c < 4; c++) begin
            cmd(8'h06, 8'h00, 8);
            cmd(8'h01, 8'(c << 2), 16);
            wait_busy();
            prot_check("R12 code");
            cmd(8'h06, 8'h00, 8);
            prot_check("R12 code with latch");
        end

        // random stream
        for (int it = 0; it < 120; it++) begin
            int sel;
            wp_n = 1'($urandom);
            sel = int'($urandom % 6);
            if ($urandom % 2 == 0) cmd(8'h06, 8'h00, 8);
            case (sel)
                0: ;
                1: cmd(8'h01, 8'($urandom), 16);
                2: cmd(8'h06, 8'h00, 8);
                3: cmd(8'h04, 8'h00, 8);
                4: cmd(8'($urandom), 8'($urandom), 8);
                default: begin
                    logic [7:0] ops [3];
                    int lens [4];
                    ops = '{8'h06, 8'h04, 8'h01};
                    lens = '{7, 9, 15, 17};
                    cmd(ops[$urandom % 3], 8'($urandom), lens[$urandom % 4]);
                end
            endcase
            read_check("R2 random read", 1 + int'($urandom % 2));
            prot_check("R12 random");
            if (m_wip) begin
                wait_busy();
                read_check("R8 random end of busy", 1);
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule